// File: doc/BRIEF.md
# FIFO Threshold and Ready-Flag Controller

This block keeps the occupancy of a paired transmit and receive FIFO, 16 entries each, inside a serial bus controller. Push and pop strobes from the bus engine and the software side move two occupancy counters. From those counters the block derives a transmit-ready flag (enough free space) and a receive-ready flag (enough unread data), each at a minimum of 1, 2 or 4 entries chosen by software.

A single 32-bit mode register sets a threshold level and a ready granularity for each direction. When the receive occupancy climbs up to its level, or the transmit occupancy drains down to its level, a sticky threshold flag is raised. Software clears these flags with a status-clear strobe. Clearing the FIFO enable empties both counters and drops both threshold flags. While the enable is low, the mode register reads back as zero.

Top module: `fifo_watermark_ctrl`

## Requirements
- R1: The mode register resets to 0. A write stores the receive threshold in bits 29:24, the transmit threshold in bits 21:16, the receive ready mode in bits 5:4 and the transmit ready mode in bits 1:0. While enabled, a read returns those fields at the same positions and zero in every other bit.
- R2: While `fifoEn` is low, `regRdData` is zero. The stored fields are kept and reappear when the enable returns high.
- R3: An accepted push raises a count by one and an accepted pop lowers it by one, visible after the clock edge. A push and a pop in the same cycle leave a non-empty count unchanged, and this includes a full FIFO.
- R4: A push to a full FIFO (16) without a pop leaves the count unchanged and raises that FIFO's overflow output for one cycle. A pop from an empty FIFO is ignored and raises that FIFO's underflow output for one cycle. A push in the same cycle as an ignored pop is still accepted.
- R5: `rxRdy` is 1 when the receive count is at least 1, 2 or 4 for ready mode 0, 1 or 2 respectively. Mode 3 acts as mode 0.
- R6: `txRdy` is 1 when free space (16 minus the transmit count) is at least 1, 2 or 4 for ready mode 0, 1 or 2 respectively. Mode 3 acts as mode 0.
- R7: `rxThrFlag` sets one cycle after the receive count changes from below the receive threshold to equal to or above it. It does not set on any other count change.
- R8: `txThrFlag` sets one cycle after the transmit count changes from above the transmit threshold to equal to or below it. It does not set on any other count change.
- R9: Rewriting a threshold without any count change never sets a threshold flag.
- R10: Threshold flags stay set until a cycle with `statClr` high clears them. A qualifying crossing evaluated in that same cycle wins and leaves the flag set.
- R11: While `fifoEn` is low, both counts are held at zero, push and pop strobes are ignored without overflow or underflow, and both threshold flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | FIFO enable; low flushes both FIFOs |
| regWrEn | input | 1 | Mode register write strobe |
| regWrData | input | 32 | Mode register write data |
| regRdData | output | 32 | Mode register read data |
| txPush | input | 1 | Transmit FIFO push strobe |
| txPop | input | 1 | Transmit FIFO pop strobe |
| rxPush | input | 1 | Receive FIFO push strobe |
| rxPop | input | 1 | Receive FIFO pop strobe |
| statClr | input | 1 | Clears both threshold flags |
| txCount | output | 5 | Transmit FIFO occupancy |
| rxCount | output | 5 | Receive FIFO occupancy |
| txRdy | output | 1 | Transmit free space meets ready mode |
| rxRdy | output | 1 | Receive data meets ready mode |
| txThrFlag | output | 1 | Sticky transmit threshold flag |
| rxThrFlag | output | 1 | Sticky receive threshold flag |
| txOvf | output | 1 | One-cycle transmit overflow pulse |
| txUnf | output | 1 | One-cycle transmit underflow pulse |
| rxOvf | output | 1 | One-cycle receive overflow pulse |
| rxUnf | output | 1 | One-cycle receive underflow pulse |

## Verification
Two cases are hard to reach from the ports. The first is a threshold-only comparison flip: the comparison result changes while the count stays put, and no flag may follow. The second is a clear strobe that lands in the same cycle as a fresh crossing. The stimulus parks the receive count at a level and rewrites the threshold first above it and then below it, so the comparison flips twice with no count movement. It then moves the transmit count up across its level and back down, and issues the clear in the exact cycle after the count lands on the level, when the crossing is being evaluated. The full and empty edges are reached by filling the transmit FIFO to 16 and draining the receive FIFO to zero, and then pushing, popping and doing both at once at those edges.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  // Mode register layout (bit positions decoded by software)
  localparam int THR_W       = 6;
  localparam int RX_THR_LSB  = 24;
  localparam int TX_THR_LSB  = 16;
  localparam int RX_MODE_LSB = 4;
  localparam int TX_MODE_LSB = 0;
  localparam int REG_W       = 32;

  typedef enum logic [1:0] {
    RDY_ONE  = 2'd0,
    RDY_TWO  = 2'd1,
    RDY_FOUR = 2'd2,
    RDY_RSV  = 2'd3
  } rdy_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic txInc;
    logic txDec;
    logic rxInc;
    logic rxDec;
  } fwc_strobe_t;

endpackage

// File: rtl/fwc_datapath.sv
module fwc_datapath
  import fwc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  fwc_strobe_t strb,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] txPrev,
  output logic [CW-1:0] rxPrev
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  // channel 0 = transmit, channel 1 = receive
  logic [1:0] incV;
  logic [1:0] decV;

  assign incV = {strb.rxInc, strb.txInc};
  assign decV = {strb.rxDec, strb.txDec};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [CW-1:0] cntQ;
    logic [CW-1:0] prvQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
        prvQ <= '0;
      end else if (strb.flush) begin
        cntQ <= '0;
        prvQ <= '0;
      end else begin
        prvQ <= cntQ;
        unique case ({incV[ch], decV[ch]})
          2'b10:   cntQ <= cntQ + CW'(1);
          2'b01:   cntQ <= cntQ - CW'(1);
          default: cntQ <= cntQ;
        endcase
      end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cntQ <= FULL_C);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(incV[ch] && !decV[ch] && cntQ == FULL_C));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(decV[ch] && cntQ == '0));
  end

  assign txCount = g_ch[0].cntQ;
  assign txPrev  = g_ch[0].prvQ;
  assign rxCount = g_ch[1].cntQ;
  assign rxPrev  = g_ch[1].prvQ;

endmodule

// File: rtl/fwc_control.sv
module fwc_control
  import fwc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             statClr,
  input  logic [CW-1:0]    txCount,
  input  logic [CW-1:0]    rxCount,
  input  logic [CW-1:0]    txPrev,
  input  logic [CW-1:0]    rxPrev,
  output fwc_strobe_t      strb,
  output logic             txRdy,
  output logic             rxRdy,
  output logic             txThrFlag,
  output logic             rxThrFlag,
  output logic             txOvf,
  output logic             txUnf,
  output logic             rxOvf,
  output logic             rxUnf
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam int XW = ((CW > THR_W) ? CW : THR_W) + 1;

  // ---------------- mode register ----------------
  logic [THR_W-1:0] rxThrQ;
  logic [THR_W-1:0] txThrQ;
  rdy_mode_e        rxModeQ;
  rdy_mode_e        txModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxThrQ  <= '0;
      txThrQ  <= '0;
      rxModeQ <= RDY_ONE;
      txModeQ <= RDY_ONE;
    end else if (regWrEn) begin
      rxThrQ  <= regWrData[RX_THR_LSB +: THR_W];
      txThrQ  <= regWrData[TX_THR_LSB +: THR_W];
      rxModeQ <= rdy_mode_e'(regWrData[RX_MODE_LSB +: 2]);
      txModeQ <= rdy_mode_e'(regWrData[TX_MODE_LSB +: 2]);
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[31:30], regWrData[23:22],
                          regWrData[15:6], regWrData[3:2]};

  always_comb begin
    regRdData = '0;
    if (fifoEn) begin
      regRdData[RX_THR_LSB +: THR_W] = rxThrQ;
      regRdData[TX_THR_LSB +: THR_W] = txThrQ;
      regRdData[RX_MODE_LSB +: 2]    = rxModeQ;
      regRdData[TX_MODE_LSB +: 2]    = txModeQ;
    end
  end

  // ---------------- accept / reject ----------------
  logic txPushOk, txPopOk, rxPushOk, rxPopOk;

  assign txPopOk  = fifoEn && txPop && (txCount != '0);
  assign rxPopOk  = fifoEn && rxPop && (rxCount != '0);
  assign txPushOk = fifoEn && txPush && ((txCount != FULL_C) || txPopOk);
  assign rxPushOk = fifoEn && rxPush && ((rxCount != FULL_C) || rxPopOk);

  always_comb begin
    strb.flush = !fifoEn;
    strb.txInc = txPushOk;
    strb.txDec = txPopOk;
    strb.rxInc = rxPushOk;
    strb.rxDec = rxPopOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOvf <= 1'b0;
      txUnf <= 1'b0;
      rxOvf <= 1'b0;
      rxUnf <= 1'b0;
    end else begin
      txOvf <= fifoEn && txPush && !txPushOk;
      txUnf <= fifoEn && txPop  && !txPopOk;
      rxOvf <= fifoEn && rxPush && !rxPushOk;
      rxUnf <= fifoEn && rxPop  && !rxPopOk;
    end
  end

  // ---------------- ready flags ----------------
  function automatic logic [CW-1:0] needOf(input rdy_mode_e m);
    unique case (m)
      RDY_TWO:  return CW'(2);
      RDY_FOUR: return CW'(4);
      default:  return CW'(1);
    endcase
  endfunction

  logic [CW-1:0] txFree;
  assign txFree = FULL_C - txCount;
  assign txRdy  = txFree  >= needOf(txModeQ);
  assign rxRdy  = rxCount >= needOf(rxModeQ);

  // ---------------- threshold crossings ----------------
  logic [XW-1:0] rxThrX, txThrX;
  logic          rxAtNow, rxAtPrev, txAtNow, txAtPrev;
  logic          rxEvt, txEvt;

  assign rxThrX   = XW'(rxThrQ);
  assign txThrX   = XW'(txThrQ);
  assign rxAtNow  = XW'(rxCount) >= rxThrX;
  assign rxAtPrev = XW'(rxPrev)  >= rxThrX;
  assign txAtNow  = XW'(txCount) <= txThrX;
  assign txAtPrev = XW'(txPrev)  <= txThrX;
  assign rxEvt    = rxAtNow && !rxAtPrev;
  assign txEvt    = txAtNow && !txAtPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxThrFlag <= 1'b0;
      txThrFlag <= 1'b0;
    end else if (!fifoEn) begin
      rxThrFlag <= 1'b0;
      txThrFlag <= 1'b0;
    end else begin
      if (rxEvt)        rxThrFlag <= 1'b1;
      else if (statClr) rxThrFlag <= 1'b0;
      if (txEvt)        txThrFlag <= 1'b1;
      else if (statClr) txThrFlag <= 1'b0;
    end
  end

  // R7
  rx_rise_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxThrFlag) |-> $past(rxCount) > $past(rxPrev));

  // R8
  tx_fall_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txThrFlag) |-> $past(txCount) < $past(txPrev));

  // R11
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |=> (txCount == '0 && rxCount == '0 && !txThrFlag && !rxThrFlag));

  // R4
  tx_ovf_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOvf |-> $past(txCount) == FULL_C);

  // R4
  rx_unf_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxUnf |-> $past(rxCount) == '0);

  // R2
  rd_zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> regRdData == '0);

endmodule

// File: rtl/fifo_watermark_ctrl.sv
module fifo_watermark_ctrl
  import fwc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             statClr,
  output logic [CW-1:0]    txCount,
  output logic [CW-1:0]    rxCount,
  output logic             txRdy,
  output logic             rxRdy,
  output logic             txThrFlag,
  output logic             rxThrFlag,
  output logic             txOvf,
  output logic             txUnf,
  output logic             rxOvf,
  output logic             rxUnf
);

  fwc_strobe_t   strb;
  logic [CW-1:0] txPrev;
  logic [CW-1:0] rxPrev;

  fwc_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEn    (fifoEn),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txPush    (txPush),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .statClr   (statClr),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txPrev    (txPrev),
    .rxPrev    (rxPrev),
    .strb      (strb),
    .txRdy     (txRdy),
    .rxRdy     (rxRdy),
    .txThrFlag (txThrFlag),
    .rxThrFlag (rxThrFlag),
    .txOvf     (txOvf),
    .txUnf     (txUnf),
    .rxOvf     (rxOvf),
    .rxUnf     (rxUnf)
  );

  fwc_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txCount (txCount),
    .rxCount (rxCount),
    .txPrev  (txPrev),
    .rxPrev  (rxPrev)
  );

endmodule

// File: tb/fifo_watermark_ctrl_tb.sv
module fifo_watermark_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic        statClr = 1'b0;
  logic [4:0]  txCount, rxCount;
  logic        txRdy, rxRdy, txThrFlag, rxThrFlag;
  logic        txOvf, txUnf, rxOvf, rxUnf;

  always #5 clk = ~clk;   // 100 MHz

  fifo_watermark_ctrl u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .statClr(statClr), .txCount(txCount), .rxCount(rxCount),
    .txRdy(txRdy), .rxRdy(rxRdy), .txThrFlag(txThrFlag), .rxThrFlag(rxThrFlag),
    .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
  );

  typedef enum int {S_TXC, S_RXC, S_TXR, S_RXR, S_TXF, S_RXF,
                    S_TXO, S_TXU, S_RXO, S_RXU, S_RD} sig_e;
  typedef struct {
    string req;
    sig_e  sig;
    int    val;
  } item_t;

  item_t scoreQ[$];
  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 1'b0;

  // current mode register contents as known to the bench
  int curRxT = 0, curTxT = 0, curRxM = 0, curTxM = 0;

  function automatic int regVal(int rT, int tT, int rM, int tM);
    return (rT << 24) | (tT << 16) | (rM << 4) | tM;
  endfunction

  function automatic int probe(sig_e s);
    case (s)
      S_TXC:   return int'(txCount);
      S_RXC:   return int'(rxCount);
      S_TXR:   return int'(txRdy);
      S_RXR:   return int'(rxRdy);
      S_TXF:   return int'(txThrFlag);
      S_RXF:   return int'(rxThrFlag);
      S_TXO:   return int'(txOvf);
      S_TXU:   return int'(txUnf);
      S_RXO:   return int'(rxOvf);
      S_RXU:   return int'(rxUnf);
      default: return int'(regRdData);
    endcase
  endfunction

  // driver side: queue an expectation for the next negedge (after the next posedge)
  task automatic want(string r, sig_e s, int v);
    item_t it;
    it.req = r;
    it.sig = s;
    it.val = v;
    scoreQ.push_back(it);
  endtask

  // monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      int    got;
      it  = scoreQ.pop_front();
      got = probe(it.sig);
      nChecks++;
      if (got != it.val) begin
        nFail++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.sig.name(), got, it.val);
      end
    end
  end

  task automatic go();
    @(negedge clk);
    #1;
    regWrEn = 1'b0;
    txPush = 1'b0; txPop = 1'b0; rxPush = 1'b0; rxPop = 1'b0;
    statClr = 1'b0;
  endtask

  task automatic wr(int rT, int tT, int rM, int tM);
    curRxT = rT; curTxT = tT; curRxM = rM; curTxM = tM;
    regWrData = 32'(regVal(rT, tT, rM, tM));
    regWrEn = 1'b1;
    want("R1", S_RD, regVal(rT, tT, rM, tM));
    go();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    go();
    go();
    // reset state
    want("R1", S_TXC, 0); want("R1", S_RXC, 0); want("R1", S_RD, 0);
    want("R1", S_TXF, 0); want("R1", S_RXF, 0); want("R6", S_TXR, 1);
    want("R5", S_RXR, 0); want("R4", S_TXO, 0);
    go();
    rstN = 1'b1;
    fifoEn = 1'b1;
    want("R1", S_RD, 0);
    go();

    wr(3, 14, 1, 2);

    // R2: disabled read is zero, fields kept
    fifoEn = 1'b0;
    want("R2", S_RD, 0);
    go();
    fifoEn = 1'b1;
    want("R2", S_RD, regVal(3, 14, 1, 2));
    go();

    // R5 / R7 receive side, mode 1 needs 2, threshold 3
    rxPush = 1'b1; want("R5", S_RXC, 1); want("R5", S_RXR, 0); go();
    rxPush = 1'b1; want("R5", S_RXC, 2); want("R5", S_RXR, 1); go();
    rxPush = 1'b1; want("R7", S_RXC, 3); want("R7", S_RXF, 0); go();
    want("R7", S_RXF, 1); go();
    statClr = 1'b1; want("R10", S_RXF, 0); go();
    want("R10", S_RXF, 0); go();
    rxPush = 1'b1; want("R3", S_RXC, 4); go();
    want("R7", S_RXF, 0); go();
    rxPop = 1'b1; want("R3", S_RXC, 3); go();
    rxPop = 1'b1; want("R3", S_RXC, 2); want("R5", S_RXR, 1); go();
    want("R7", S_RXF, 0); go();
    rxPush = 1'b1; want("R7", S_RXC, 3); go();
    want("R7", S_RXF, 1); go();
    statClr = 1'b1; want("R10", S_RXF, 0); go();

    // R9: threshold rewrites with count held at 3
    wr(5, 14, 1, 2);
    want("R9", S_RXF, 0); go();
    wr(2, 14, 1, 2);
    want("R9", S_RXF, 0); go();
    want("R9", S_RXF, 0); go();

    // R5: mode 2 needs 4, mode 3 acts as mode 0
    wr(2, 14, 2, 2);
    want("R5", S_RXR, 0); go();
    rxPush = 1'b1; want("R5", S_RXC, 4); want("R5", S_RXR, 1); go();
    wr(2, 14, 3, 2);
    rxPush = 1'b1; rxPop = 1'b1; want("R3", S_RXC, 4); go();
    for (int k = 3; k >= 0; k--) begin
      rxPop = 1'b1;
      want("R3", S_RXC, k);
      want("R5", S_RXR, (k >= 1) ? 1 : 0);
      go();
    end
    rxPop = 1'b1; want("R4", S_RXU, 1); want("R4", S_RXC, 0); go();
    want("R4", S_RXU, 0); go();
    rxPush = 1'b1; rxPop = 1'b1; want("R4", S_RXC, 1); want("R4", S_RXU, 1); go();

    // R6 / R8 transmit side, threshold 14, mode 2 needs 4 free
    for (int i = 1; i <= 16; i++) begin
      txPush = 1'b1;
      want("R3", S_TXC, i);
      want("R6", S_TXR, ((16 - i) >= 4) ? 1 : 0);
      go();
    end
    want("R8", S_TXF, 0); go();
    txPush = 1'b1; want("R4", S_TXO, 1); want("R4", S_TXC, 16); go();
    want("R4", S_TXO, 0); go();
    txPush = 1'b1; txPop = 1'b1; want("R3", S_TXC, 16); want("R4", S_TXO, 0); go();
    wr(2, 14, 3, 3);
    want("R6", S_TXR, 0); go();
    txPop = 1'b1; want("R6", S_TXC, 15); want("R6", S_TXR, 1); go();
    wr(2, 14, 3, 1);
    want("R6", S_TXR, 0); want("R8", S_TXF, 0); go();
    txPop = 1'b1; want("R8", S_TXC, 14); want("R6", S_TXR, 1); go();
    want("R8", S_TXF, 1); go();

    // R10: clear in the cycle a crossing is evaluated
    statClr = 1'b1; want("R10", S_TXF, 0); go();
    txPush = 1'b1; want("R8", S_TXC, 15); go();
    txPop = 1'b1; want("R8", S_TXC, 14); want("R10", S_TXF, 0); go();
    statClr = 1'b1; want("R10", S_TXF, 1); go();
    want("R10", S_TXF, 1); go();

    // R11: disable flushes, ignores strobes
    fifoEn = 1'b0;
    want("R11", S_TXC, 0); want("R11", S_RXC, 0);
    want("R11", S_TXF, 0); want("R2", S_RD, 0);
    go();
    fifoEn = 1'b0; txPush = 1'b1; rxPop = 1'b1;
    want("R11", S_TXC, 0); want("R11", S_TXO, 0); want("R11", S_RXU, 0);
    go();
    fifoEn = 1'b1;
    want("R11", S_TXC, 0); want("R11", S_TXF, 0); want("R11", S_RXF, 0);
    want("R2", S_RD, regVal(curRxT, curTxT, curRxM, curTxM));
    go();
    go();

    done = 1'b1;
    finishRun();
  end

endmodule